// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds sixteen 32-bit general registers for a processor core. The lower eight register numbers are backed twice, once in a low bank and once in a high bank. The upper eight numbers always reach one shared set. The core presents two status bits, a privilege bit and a bank-select bit. The high bank is visible only when both bits are 1. For any other pair of values, the low bank is visible.

Normal traffic uses two read ports and one write port, all addressed by 4-bit register numbers. A side port addresses the bank that is currently hidden with a 3-bit number, for both reads and writes. Context-switch code uses it to save and restore the other bank's values.

A stepping port adjusts one register by 1, 2 or 4, upward or downward. It also returns the address that the matching memory access must use. For a downward step this is the stepped value (decrement first). For an upward step it is the value before the step (increment afterwards).

All read data is registered.

Top module: `regbank_rf`

## Requirements
- R1: A synchronous reset clears every physical register and every output to zero, and selects the high bank as the visible one. The bank is the one a privilege bit of 1 with a bank bit of 1 would give.
- R2: A read port samples its register at a clock edge. The value appears on its data output after that edge.
- R3: A read of a register that is written at the same edge returns the value it held before the write. There is no bypass.
- R4: Register numbers 0 to 7 reach the high bank only when `mode_priv` and `bank_sel` are both 1. In the other three combinations they reach the low bank.
- R5: Register numbers 8 to 15 reach the same storage whatever the status bits are.
- R6: A change of `mode_priv` or `bank_sel` affects reads and writes from the following edge on. The edge at which the change is sampled still uses the previous bank.
- R7: The side port reads and writes entry 0 to 7 of the bank that is not visible. Its writes leave the visible bank unchanged.
- R8: When the write port and the stepping port target the same register at the same edge, the write port's data is stored. `step_addr` still reports the result based on the register's previous value.
- R9: `step_size` encodes the step as 0 for 1, 1 for 2, and 2 or 3 for 4. `step_down` = 0 adds and `step_down` = 1 subtracts. `step_addr` shows the stepped value for a downward step and the previous value for an upward step. The register keeps the stepped value, and `step_addr` holds when `step_en` is 0.
- R10: Stepping wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_priv | input | 1 | Privilege status bit |
| bank_sel | input | 1 | Bank-select status bit |
| rd_a_idx | input | 4 | Register number, read port A |
| rd_a_data | output | 32 | Registered data, read port A |
| rd_b_idx | input | 4 | Register number, read port B |
| rd_b_data | output | 32 | Registered data, read port B |
| wr_en | input | 1 | Write enable, normal port |
| wr_idx | input | 4 | Register number, normal write |
| wr_data | input | 32 | Write data, normal port |
| alt_rd_idx | input | 3 | Hidden-bank entry to read |
| alt_rd_data | output | 32 | Registered hidden-bank read data |
| alt_wr_en | input | 1 | Hidden-bank write enable |
| alt_wr_idx | input | 3 | Hidden-bank entry to write |
| alt_wr_data | input | 32 | Hidden-bank write data |
| step_en | input | 1 | Step enable |
| step_idx | input | 4 | Register number to step |
| step_down | input | 1 | 1 subtracts, 0 adds |
| step_size | input | 2 | Step size code |
| step_addr | output | 32 | Registered access address from the last step |

## Verification
The assertions check four things on every cycle:
- the zero state after reset;
- that a normal write is returned by a read one edge later when the status bits are steady;
- the same for a side-port write followed by a side-port read;
- that two back-to-back steps on one register give addresses consistent with each other.

Several behaviours depend on values that no port exposes at the same time, so only the bench scenarios can show them:
- bank selection over all four status combinations;
- the one-edge delay of a status change;
- the old value seen by a read at the same edge as a write;
- write-over-step priority;
- wrap-around.

A behavioural model in the bench runs in parallel and compares all four outputs on every clock under random traffic.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef logic [1:0] step_code_t;

  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_dir_e;

  // Shift that turns the size code into 1, 2 or 4.
  function automatic logic [1:0] step_shift(input step_code_t code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/regbank_map.sv
// Turns a register number and the visible-bank flag into a storage slot.
// Slots: [0, BANKED) low bank, [BANKED, 2*BANKED) high bank, rest shared.
module regbank_map #(
  parameter int BANKED   = 8,
  parameter int SHARED   = 8,
  parameter bit ALT_SIDE = 1'b0,
  parameter int LIDX_W   = $clog2(BANKED + SHARED),
  parameter int PIDX_W   = $clog2(2 * BANKED + SHARED)
) (
  input  logic [LIDX_W-1:0] lidx,
  input  logic              view_hi,
  output logic [PIDX_W-1:0] phys
);

  localparam logic [PIDX_W-1:0] BANK_OFS = PIDX_W'(BANKED);

  generate
    if (ALT_SIDE) begin : g_hidden
      // Side port always reaches the bank that is not visible.
      assign phys = view_hi ? PIDX_W'(lidx) : PIDX_W'(lidx) + BANK_OFS;
    end else begin : g_visible
      always_comb begin
        if (lidx < LIDX_W'(BANKED))
          phys = view_hi ? PIDX_W'(lidx) + BANK_OFS : PIDX_W'(lidx);
        else
          phys = PIDX_W'(lidx) + BANK_OFS;
      end
    end
  endgenerate

endmodule

// File: rtl/regbank_stepper.sv
// Computes the stepped value and the access address for a step request.
module regbank_stepper
  import regbank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  step_dir_e       dir,
  input  step_code_t      size,
  output logic [XLEN-1:0] new_val,
  output logic [XLEN-1:0] addr
);

  logic [XLEN-1:0] amount;

  always_comb begin
    amount  = XLEN'(1) << step_shift(size);
    new_val = (dir == STEP_DOWN) ? old_val - amount : old_val + amount;
    // Decrement happens before the access, increment after it.
    addr    = (dir == STEP_DOWN) ? new_val : old_val;
  end

endmodule

// File: rtl/regbank_store.sv
// Flat storage with three prioritised writers and registered reads.
module regbank_store #(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 24,
  parameter int PIDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_phys,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              st_en,
  input  logic [PIDX_W-1:0] st_phys,
  input  logic [XLEN-1:0]   st_data,
  input  logic              alt_en,
  input  logic [PIDX_W-1:0] alt_phys,
  input  logic [XLEN-1:0]   alt_data,
  input  logic [PIDX_W-1:0] rd_a_phys,
  input  logic [PIDX_W-1:0] rd_b_phys,
  input  logic [PIDX_W-1:0] rd_alt_phys,
  input  logic [PIDX_W-1:0] st_rd_phys,
  output logic [XLEN-1:0]   rd_a_q,
  output logic [XLEN-1:0]   rd_b_q,
  output logic [XLEN-1:0]   rd_alt_q,
  output logic [XLEN-1:0]   st_old
);

  logic [XLEN-1:0] mem [ENTRIES];

  // Priority: normal write over step over hidden-bank write.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && wr_phys == PIDX_W'(e))
          mem[e] <= wr_data;
        else if (st_en && st_phys == PIDX_W'(e))
          mem[e] <= st_data;
        else if (alt_en && alt_phys == PIDX_W'(e))
          mem[e] <= alt_data;
      end
    end
  end

  // Reads see the contents before this edge's writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_q   <= '0;
      rd_b_q   <= '0;
      rd_alt_q <= '0;
    end else begin
      rd_a_q   <= mem[rd_a_phys];
      rd_b_q   <= mem[rd_b_phys];
      rd_alt_q <= mem[rd_alt_phys];
    end
  end

  assign st_old = mem[st_rd_phys];

endmodule

// File: rtl/regbank_rf.sv
module regbank_rf
  import regbank_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BANKED = 8,
  parameter int SHARED = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_priv,
  input  logic                        bank_sel,
  input  logic [$clog2(BANKED+SHARED)-1:0] rd_a_idx,
  output logic [XLEN-1:0]             rd_a_data,
  input  logic [$clog2(BANKED+SHARED)-1:0] rd_b_idx,
  output logic [XLEN-1:0]             rd_b_data,
  input  logic                        wr_en,
  input  logic [$clog2(BANKED+SHARED)-1:0] wr_idx,
  input  logic [XLEN-1:0]             wr_data,
  input  logic [$clog2(BANKED)-1:0]   alt_rd_idx,
  output logic [XLEN-1:0]             alt_rd_data,
  input  logic                        alt_wr_en,
  input  logic [$clog2(BANKED)-1:0]   alt_wr_idx,
  input  logic [XLEN-1:0]             alt_wr_data,
  input  logic                        step_en,
  input  logic [$clog2(BANKED+SHARED)-1:0] step_idx,
  input  logic                        step_down,
  input  logic [1:0]                  step_size,
  output logic [XLEN-1:0]             step_addr
);

  localparam int NREG    = BANKED + SHARED;
  localparam int ENTRIES = 2 * BANKED + SHARED;
  localparam int LIDX_W  = $clog2(NREG);
  localparam int AIDX_W  = $clog2(BANKED);
  localparam int PIDX_W  = $clog2(ENTRIES);
  localparam int NVIS    = 4;  // read A, read B, write, step
  localparam int NHID    = 2;  // hidden read, hidden write

  // Visible bank flag, latched so a status change applies one edge later.
  logic view_hi;
  always_ff @(posedge clk) begin
    if (rst) view_hi <= 1'b1;
    else     view_hi <= mode_priv & bank_sel;
  end

  logic [NVIS-1:0][LIDX_W-1:0] vis_idx;
  logic [NVIS-1:0][PIDX_W-1:0] vis_phys;
  logic [NHID-1:0][LIDX_W-1:0] hid_idx;
  logic [NHID-1:0][PIDX_W-1:0] hid_phys;

  assign vis_idx = {step_idx, wr_idx, rd_b_idx, rd_a_idx};
  assign hid_idx = {LIDX_W'(alt_wr_idx), LIDX_W'(alt_rd_idx)};

  for (genvar p = 0; p < NVIS; p++) begin : g_vis_map
    regbank_map #(
      .BANKED(BANKED), .SHARED(SHARED), .ALT_SIDE(1'b0),
      .LIDX_W(LIDX_W), .PIDX_W(PIDX_W)
    ) u_map (
      .lidx(vis_idx[p]), .view_hi(view_hi), .phys(vis_phys[p])
    );
  end

  for (genvar h = 0; h < NHID; h++) begin : g_hid_map
    regbank_map #(
      .BANKED(BANKED), .SHARED(SHARED), .ALT_SIDE(1'b1),
      .LIDX_W(LIDX_W), .PIDX_W(PIDX_W)
    ) u_map (
      .lidx(hid_idx[h]), .view_hi(view_hi), .phys(hid_phys[h])
    );
  end

  logic [XLEN-1:0] st_old, st_new, st_addr;

  regbank_stepper #(.XLEN(XLEN)) u_step (
    .old_val(st_old),
    .dir    (step_dir_e'(step_down)),
    .size   (step_size),
    .new_val(st_new),
    .addr   (st_addr)
  );

  regbank_store #(.XLEN(XLEN), .ENTRIES(ENTRIES), .PIDX_W(PIDX_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_phys    (vis_phys[2]),
    .wr_data    (wr_data),
    .st_en      (step_en),
    .st_phys    (vis_phys[3]),
    .st_data    (st_new),
    .alt_en     (alt_wr_en),
    .alt_phys   (hid_phys[1]),
    .alt_data   (alt_wr_data),
    .rd_a_phys  (vis_phys[0]),
    .rd_b_phys  (vis_phys[1]),
    .rd_alt_phys(hid_phys[0]),
    .st_rd_phys (vis_phys[3]),
    .rd_a_q     (rd_a_data),
    .rd_b_q     (rd_b_data),
    .rd_alt_q   (alt_rd_data),
    .st_old     (st_old)
  );

  always_ff @(posedge clk) begin
    if (rst)          step_addr <= '0;
    else if (step_en) step_addr <= st_addr;
  end

endmodule

// File: rtl/regbank_rf_chk.sv
module regbank_rf_chk #(
  parameter int XLEN   = 32,
  parameter int LIDX_W = 4,
  parameter int AIDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_priv,
  input logic              bank_sel,
  input logic [LIDX_W-1:0] rd_a_idx,
  input logic [XLEN-1:0]   rd_a_data,
  input logic [XLEN-1:0]   rd_b_data,
  input logic              wr_en,
  input logic [LIDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]   wr_data,
  input logic [AIDX_W-1:0] alt_rd_idx,
  input logic [XLEN-1:0]   alt_rd_data,
  input logic              alt_wr_en,
  input logic [AIDX_W-1:0] alt_wr_idx,
  input logic [XLEN-1:0]   alt_wr_data,
  input logic              step_en,
  input logic [LIDX_W-1:0] step_idx,
  input logic              step_down,
  input logic [1:0]        step_size,
  input logic [XLEN-1:0]   step_addr
);

  function automatic logic [XLEN-1:0] size_to_amt(input logic [1:0] c);
    if (c == 2'd0)      return XLEN'(1);
    else if (c == 2'd1) return XLEN'(2);
    else                return XLEN'(4);
  endfunction

  logic rst_q, mode_q, bank_q;
  logic view_steady;
  logic              p_wr_v,  p_alt_v,  p_st_v,  p_st_down;
  logic [LIDX_W-1:0] p_wr_idx, p_st_idx;
  logic [AIDX_W-1:0] p_alt_idx;
  logic [XLEN-1:0]   p_wr_data, p_alt_data, p_st_amt;
  logic [XLEN-1:0]   step_expect;

  // Bank seen at this edge equals the bank seen at the previous edge.
  assign view_steady = !rst_q && mode_priv == mode_q && bank_sel == bank_q;

  assign step_expect = (p_st_down ? step_addr : step_addr + p_st_amt)
                       - (step_down ? size_to_amt(step_size) : '0);

  always_ff @(posedge clk) begin
    rst_q  <= rst;
    mode_q <= mode_priv;
    bank_q <= bank_sel;
    if (rst) begin
      p_wr_v <= 1'b0; p_alt_v <= 1'b0; p_st_v <= 1'b0; p_st_down <= 1'b0;
      p_wr_idx <= '0; p_st_idx <= '0; p_alt_idx <= '0;
      p_wr_data <= '0; p_alt_data <= '0; p_st_amt <= '0;
    end else begin
      p_wr_v     <= wr_en && view_steady;
      p_wr_idx   <= wr_idx;
      p_wr_data  <= wr_data;
      p_alt_v    <= alt_wr_en && view_steady;
      p_alt_idx  <= alt_wr_idx;
      p_alt_data <= alt_wr_data;
      p_st_v     <= step_en && !wr_en && view_steady;
      p_st_idx   <= step_idx;
      p_st_down  <= step_down;
      p_st_amt   <= size_to_amt(step_size);
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) begin
      reset_zero_chk: assert (rd_a_data == '0 && rd_b_data == '0 &&
                              alt_rd_data == '0 && step_addr == '0)
        else $error("outputs not cleared by reset");
    end
  end

  // R2
  write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
    (p_wr_v && view_steady && rd_a_idx == p_wr_idx)
      |=> rd_a_data == $past(p_wr_data));

  // R7
  hidden_write_read_chk: assert property (@(posedge clk) disable iff (rst)
    (p_alt_v && view_steady && alt_rd_idx == p_alt_idx)
      |=> alt_rd_data == $past(p_alt_data));

  // R9
  step_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (p_st_v && step_en && step_idx == p_st_idx && view_steady)
      |=> step_addr == $past(step_expect));

endmodule

bind regbank_rf regbank_rf_chk #(
  .XLEN(XLEN), .LIDX_W(LIDX_W), .AIDX_W(AIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .mode_priv(mode_priv), .bank_sel(bank_sel),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .alt_rd_idx(alt_rd_idx), .alt_rd_data(alt_rd_data),
  .alt_wr_en(alt_wr_en), .alt_wr_idx(alt_wr_idx), .alt_wr_data(alt_wr_data),
  .step_en(step_en), .step_idx(step_idx), .step_down(step_down),
  .step_size(step_size), .step_addr(step_addr)
);

// File: tb/test_regbank_rf.sv
`timescale 1ns/1ps
module test_regbank_rf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_priv = 1'b1, bank_sel = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, step_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, alt_rd_data, step_addr;
  logic        wr_en = 1'b0, alt_wr_en = 1'b0, step_en = 1'b0, step_down = 1'b0;
  logic [31:0] wr_data = '0, alt_wr_data = '0;
  logic [2:0]  alt_rd_idx = '0, alt_wr_idx = '0;
  logic [1:0]  step_size = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regbank_rf i_regbank_rf (
    .clk(clk), .rst(rst), .mode_priv(mode_priv), .bank_sel(bank_sel),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .alt_rd_idx(alt_rd_idx), .alt_rd_data(alt_rd_data),
    .alt_wr_en(alt_wr_en), .alt_wr_idx(alt_wr_idx), .alt_wr_data(alt_wr_data),
    .step_en(step_en), .step_idx(step_idx), .step_down(step_down),
    .step_size(step_size), .step_addr(step_addr)
  );

  // Behavioural reference: separate arrays for low bank, high bank, shared.
  logic [31:0] m_lo [8];
  logic [31:0] m_hi [8];
  logic [31:0] m_sh [8];
  bit          m_view;
  logic [31:0] e_a = '0, e_b = '0, e_alt = '0, e_st = '0;
  logic [31:0] m_old, m_new, m_amt;

  function automatic logic [31:0] mread(int n, bit hi);
    if (n >= 8)  return m_sh[n-8];
    else if (hi) return m_hi[n];
    else         return m_lo[n];
  endfunction

  task automatic mwrite(int n, bit hi, logic [31:0] d);
    if (n >= 8)  m_sh[n-8] = d;
    else if (hi) m_hi[n] = d;
    else         m_lo[n] = d;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 8; k++) begin m_lo[k] = '0; m_hi[k] = '0; m_sh[k] = '0; end
      m_view = 1'b1;
      e_a = '0; e_b = '0; e_alt = '0; e_st = '0;
    end else begin
      e_a   = mread(int'(rd_a_idx), m_view);
      e_b   = mread(int'(rd_b_idx), m_view);
      e_alt = mread(int'(alt_rd_idx), !m_view);
      m_new = '0;
      if (step_en) begin
        m_old = mread(int'(step_idx), m_view);
        m_amt = (step_size == 2'd0) ? 32'd1 : (step_size == 2'd1) ? 32'd2 : 32'd4;
        m_new = step_down ? m_old - m_amt : m_old + m_amt;
        e_st  = step_down ? m_new : m_old;
      end
      if (alt_wr_en) mwrite(int'(alt_wr_idx), !m_view, alt_wr_data);
      if (step_en)   mwrite(int'(step_idx), m_view, m_new);
      if (wr_en)     mwrite(int'(wr_idx), m_view, wr_data);
      m_view = mode_priv & bank_sel;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check("R2 model read A", rd_a_data, e_a);
      check("R2 model read B", rd_b_data, e_b);
      check("R7 model hidden read", alt_rd_data, e_alt);
      check("R9 model step address", step_addr, e_st);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1: cleared outputs after reset
    check("R1 reset A", rd_a_data, 32'h0);
    check("R1 reset step", step_addr, 32'h0);
    rst = 1'b0;

    // R3: same-edge read returns old value
    wr_en = 1; wr_idx = 4'd3; wr_data = 32'h1111_0003; rd_a_idx = 4'd3;
    cyc(); check("R3 old value", rd_a_data, 32'h0);
    wr_en = 0;
    cyc(); check("R2 read after write", rd_a_data, 32'h1111_0003);

    // R7: hidden bank write does not touch visible bank
    alt_wr_en = 1; alt_wr_idx = 3'd3; alt_wr_data = 32'hAAAA_0003;
    cyc(); alt_wr_en = 0; alt_rd_idx = 3'd3;
    cyc(); check("R7 visible unchanged", rd_a_data, 32'h1111_0003);
    check("R7 hidden read", alt_rd_data, 32'hAAAA_0003);

    // R6 / R4: status change
    bank_sel = 0;
    cyc(); check("R6 old bank at change edge", rd_a_data, 32'h1111_0003);
    cyc(); check("R4 low bank when bank bit 0", rd_a_data, 32'hAAAA_0003);
    check("R7 hidden is high bank", alt_rd_data, 32'h1111_0003);
    mode_priv = 0; bank_sel = 1;
    cyc(); cyc(); check("R4 low bank when mode bit 0", rd_a_data, 32'hAAAA_0003);
    mode_priv = 1;
    cyc(); cyc(); check("R4 high bank when both 1", rd_a_data, 32'h1111_0003);

    // R5: shared upper registers
    wr_en = 1; wr_idx = 4'd9; wr_data = 32'h9999_0009;
    cyc(); wr_en = 0; mode_priv = 0; rd_b_idx = 4'd9;
    cyc(); cyc(); check("R5 shared across banks", rd_b_data, 32'h9999_0009);

    // R9: stepping sequence
    wr_en = 1; wr_idx = 4'd10; wr_data = 32'h100;
    cyc(); wr_en = 0;
    step_en = 1; step_idx = 4'd10; step_down = 0; step_size = 2'd0;
    cyc(); check("R9 inc by 1 old addr", step_addr, 32'h100);
    step_down = 1; step_size = 2'd1;
    cyc(); check("R9 dec by 2 new addr", step_addr, 32'hFF);
    step_size = 2'd2;
    cyc(); check("R9 dec by 4 new addr", step_addr, 32'hFB);
    step_down = 0; step_size = 2'd3;
    cyc(); check("R9 inc code 3 old addr", step_addr, 32'hFB);
    step_en = 0; rd_a_idx = 4'd10;
    cyc(); check("R9 register holds stepped value", rd_a_data, 32'hFF);
    check("R9 addr holds when idle", step_addr, 32'hFB);

    // R10: wrap below zero
    step_en = 1; step_idx = 4'd11; step_down = 1; step_size = 2'd2;
    cyc(); check("R10 wrap", step_addr, 32'hFFFF_FFFC);
    step_en = 0;

    // R8: write wins over step
    wr_en = 1; wr_idx = 4'd12; wr_data = 32'h5;
    cyc(); wr_data = 32'h77;
    step_en = 1; step_idx = 4'd12; step_down = 0; step_size = 2'd2;
    cyc(); check("R8 step addr from old value", step_addr, 32'h5);
    wr_en = 0; step_en = 0; rd_a_idx = 4'd12;
    cyc(); check("R8 write data kept", rd_a_data, 32'h77);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      rd_a_idx    = 4'($urandom);
      rd_b_idx    = 4'($urandom);
      alt_rd_idx  = 3'($urandom);
      wr_en       = ($urandom % 2) == 0;
      wr_idx      = 4'($urandom);
      wr_data     = $urandom;
      alt_wr_en   = ($urandom % 3) == 0;
      alt_wr_idx  = 3'($urandom);
      alt_wr_data = $urandom;
      step_en     = ($urandom % 3) == 0;
      step_idx    = 4'($urandom);
      step_down   = 1'($urandom);
      step_size   = 2'($urandom);
      if (($urandom % 8) == 0) mode_priv = ~mode_priv;
      if (($urandom % 8) == 0) bank_sel  = ~bank_sel;
      cyc();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule